// File: doc/BRIEF.md
# Dual-Rail Precharged Logic Unit

This block performs a bitwise AND, OR, XOR or XNOR on two operands, with every internal signal carried as a pair of wires: a true rail and a false rail. An internal phase register alternates the datapath between a precharge cycle, in which every rail in the network is held low, and an evaluate cycle, in which exactly one rail of each pair rises. Every bit therefore makes the same number of wire transitions in every cycle, whatever its value.

Single-rail operands and the operation code are converted at the edge of the block by a stage that gates them with the evaluate phase, so the precharge zeros enter at the inputs and sweep through the network. Inside the network only non-inverting gate pairs are used. An inversion is a swap of the two rails. The operation selection is itself built from dual-rail gates. A registered copy of both rails is presented at the outputs, together with a single-rail result captured at the end of each evaluate cycle and a one-cycle valid pulse. A per-bit rail checker raises an error bit if both rails of a result bit are ever high together, or if neither is high when an evaluate cycle ends.

Top module: `dr_datapath`

## Requirements
- R1: While reset is high and right after it, `phase_o`, `vld_o`, `res_o`, both rail outputs and `err_o` are all zero. The first cycle after reset is a precharge cycle.
- R2: `phase_o` inverts on every clock edge once reset is released. A value of 1 marks an evaluate cycle and 0 marks a precharge cycle.
- R3: After a clock edge taken in a precharge cycle, `rail_t_o` and `rail_f_o` are all zero, whatever the values on `a_i`, `b_i` and `op_i`.
- R4: After a clock edge taken in an evaluate cycle, each result bit has exactly one rail high, so `rail_t_o` equals the bitwise inverse of `rail_f_o`, and `rail_t_o` equals `res_o`.
- R5: When `op_i` is 0, the captured result is `a_i & b_i`.
- R6: When `op_i` is 1, the captured result is `a_i | b_i`.
- R7: When `op_i` is 2, the captured result is `a_i ^ b_i`.
- R8: When `op_i` is 3, the captured result is `~(a_i ^ b_i)`.
- R9: `vld_o` is high for exactly the one cycle that follows each evaluate-cycle clock edge, and it is low at all other times.
- R10: `res_o` changes only at an evaluate-cycle edge. Operand or operation changes made during a precharge cycle have no effect on `res_o`.
- R11: `err_o` stays all zero for any legal sequence of inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | W | First operand, single-rail |
| b_i | input | W | Second operand, single-rail |
| op_i | input | 2 | Operation: 0 AND, 1 OR, 2 XOR, 3 XNOR |
| phase_o | output | 1 | 1 during an evaluate cycle, 0 during precharge |
| rail_t_o | output | W | Registered true rails of the result |
| rail_f_o | output | W | Registered false rails of the result |
| res_o | output | W | Result captured at the end of evaluate |
| vld_o | output | 1 | One-cycle pulse after each capture |
| err_o | output | W | Per-bit rail violation flags |

## Verification
Suppose a gate pair mixes up its rails, or a precharge gate is missing. The fault then appears at the outputs on the very next clock edge. One case is a rail pair that is not complementary in the valid cycle. Another is a rail left high in the following precharge cycle. A third is a wrong result value, and the checker bit also rises in `err_o` on that same edge. A phase register that stops alternating shows up as a missing `vld_o` pulse within two cycles. The operands are swept over every value pair for all four operations. This means a faulty rail on any bit, under any operation, affects at least one checked output.

// File: rtl/drl_pkg.sv
package drl_pkg;

  typedef struct packed {
    logic t;
    logic f;
  } dual_t;

  localparam int OP_W = 2;
  localparam int NSEL = 1 << OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_XOR  = 2'd2,
    OP_XNOR = 2'd3
  } op_e;

  // Positive gate pair: AND on true rails, OR on false rails
  function automatic dual_t dr_and(dual_t x, dual_t y);
    dual_t r;
    r.t = x.t & y.t;
    r.f = x.f | y.f;
    return r;
  endfunction

  // Positive gate pair: OR on true rails, AND on false rails
  function automatic dual_t dr_or(dual_t x, dual_t y);
    dual_t r;
    r.t = x.t | y.t;
    r.f = x.f & y.f;
    return r;
  endfunction

  // Inversion is a plain rail swap, no inverting gate
  function automatic dual_t dr_not(dual_t x);
    dual_t r;
    r.t = x.f;
    r.f = x.t;
    return r;
  endfunction

  function automatic dual_t dr_xor(dual_t x, dual_t y);
    dual_t r;
    r.t = (x.t & y.f) | (x.f & y.t);
    r.f = (x.t & y.t) | (x.f & y.f);
    return r;
  endfunction

endpackage

// File: rtl/dr_input_stage.sv
module dr_input_stage
  import drl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              eval_i,
  input  logic [W-1:0]      d_i,
  output dual_t [W-1:0]     q_o
);

  // The single inversion of the datapath lives here, at the boundary;
  // both rails are gated so precharge zeros start the wave.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_o[i].t = eval_i & d_i[i];
    assign q_o[i].f = eval_i & ~d_i[i];
  end

endmodule

// File: rtl/dr_logic_unit.sv
module dr_logic_unit
  import drl_pkg::*;
#(
  parameter int W = 4
) (
  input  dual_t [W-1:0]    a_i,
  input  dual_t [W-1:0]    b_i,
  input  dual_t [OP_W-1:0] op_i,
  output dual_t [W-1:0]    y_o
);

  function automatic dual_t and_all(dual_t [OP_W-1:0] v);
    dual_t acc;
    acc = v[0];
    for (int j = 1; j < OP_W; j++) acc = dr_and(acc, v[j]);
    return acc;
  endfunction

  function automatic dual_t pick(dual_t [NSEL-1:0] s, dual_t [NSEL-1:0] c);
    dual_t acc;
    acc = dr_and(s[0], c[0]);
    for (int k = 1; k < NSEL; k++) acc = dr_or(acc, dr_and(s[k], c[k]));
    return acc;
  endfunction

  dual_t [NSEL-1:0] sel;

  // One-hot decode of the operation code in dual-rail form
  for (genvar k = 0; k < NSEL; k++) begin : g_dec
    dual_t [OP_W-1:0] lit;
    for (genvar j = 0; j < OP_W; j++) begin : g_lit
      if (((k >> j) & 1) == 1) begin : g_pos
        assign lit[j] = op_i[j];
      end else begin : g_neg
        assign lit[j] = dr_not(op_i[j]);
      end
    end
    assign sel[k] = and_all(lit);
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    dual_t [NSEL-1:0] cand;
    dual_t            x;
    assign x               = dr_xor(a_i[i], b_i[i]);
    assign cand[OP_AND]    = dr_and(a_i[i], b_i[i]);
    assign cand[OP_OR]     = dr_or(a_i[i], b_i[i]);
    assign cand[OP_XOR]    = x;
    assign cand[OP_XNOR]   = dr_not(x);
    assign y_o[i]          = pick(sel, cand);
  end

endmodule

// File: rtl/dr_rail_checker.sv
module dr_rail_checker
  import drl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eval_i,
  input  dual_t [W-1:0] net_i,
  output logic [W-1:0]  err_o
);

  logic [W-1:0] both_hi;
  logic [W-1:0] none_hi;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign both_hi[i] = net_i[i].t & net_i[i].f;
    assign none_hi[i] = ~net_i[i].t & ~net_i[i].f;
  end

  always_ff @(posedge clk) begin
    if (rst) err_o <= '0;
    else     err_o <= both_hi | (none_hi & {W{eval_i}});
  end

  // R3
  precharge_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !eval_i |-> (both_hi == '0 && none_hi == '1));

  // R4
  eval_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    eval_i |-> (both_hi == '0 && none_hi == '0));

endmodule

// File: rtl/dr_datapath.sv
module dr_datapath
  import drl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic            phase_o,
  output logic [W-1:0]    rail_t_o,
  output logic [W-1:0]    rail_f_o,
  output logic [W-1:0]    res_o,
  output logic            vld_o,
  output logic [W-1:0]    err_o
);

  logic            eval_q;
  dual_t [W-1:0]   a_d, b_d, y_d;
  dual_t [OP_W-1:0] op_d;
  logic [W-1:0]    y_t, y_f;
  logic [W-1:0]    rt_q, rf_q, res_q;
  logic            vld_q;

  always_ff @(posedge clk) begin
    if (rst) eval_q <= 1'b0;
    else     eval_q <= ~eval_q;
  end

  dr_input_stage #(.W(W))    u_in_a  (.eval_i(eval_q), .d_i(a_i),  .q_o(a_d));
  dr_input_stage #(.W(W))    u_in_b  (.eval_i(eval_q), .d_i(b_i),  .q_o(b_d));
  dr_input_stage #(.W(OP_W)) u_in_op (.eval_i(eval_q), .d_i(op_i), .q_o(op_d));

  dr_logic_unit #(.W(W)) u_net (.a_i(a_d), .b_i(b_d), .op_i(op_d), .y_o(y_d));

  dr_rail_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .eval_i(eval_q), .net_i(y_d), .err_o(err_o)
  );

  for (genvar i = 0; i < W; i++) begin : g_split
    assign y_t[i] = y_d[i].t;
    assign y_f[i] = y_d[i].f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_q  <= '0;
      rf_q  <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      rt_q  <= y_t;
      rf_q  <= y_f;
      vld_q <= eval_q;
      if (eval_q) res_q <= y_t;
    end
  end

  assign phase_o  = eval_q;
  assign rail_t_o = rt_q;
  assign rail_f_o = rf_q;
  assign res_o    = res_q;
  assign vld_o    = vld_q;

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (eval_q != $past(eval_q)));

  // R9
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);

  // R9
  vld_after_eval_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> $past(eval_q));

  // R4
  out_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (rt_q == ~rf_q && rt_q == res_q));

  // R3
  out_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> (rt_q == '0 && rf_q == '0));

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> $stable(res_q));

endmodule

// File: tb/test_dr_datapath.sv
`timescale 1ns/1ps
module test_dr_datapath;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [1:0]   op_i = '0;
  logic         phase_o, vld_o;
  logic [W-1:0] rail_t_o, rail_f_o, res_o, err_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dr_datapath #(.W(W)) i_dr_datapath (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .phase_o(phase_o), .rail_t_o(rail_t_o), .rail_f_o(rail_f_o),
    .res_o(res_o), .vld_o(vld_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [1:0] op);
    case (op)
      2'd0:    return a & b;
      2'd1:    return a | b;
      2'd2:    return a ^ b;
      default: return ~(a ^ b);
    endcase
  endfunction

  function automatic string op_req(logic [1:0] op);
    case (op)
      2'd0:    return "R5";
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  // One precharge + evaluate round; verbose adds the per-cycle checks
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [1:0] op, input bit verbose);
    logic [W-1:0] e;
    e = model(a, b, op);
    @(negedge clk);
    while (phase_o !== 1'b0) @(negedge clk);
    a_i = a; b_i = b; op_i = op;
    @(negedge clk);
    if (verbose) begin
      chk(phase_o === 1'b1, "R2", "phase evaluate", 32'(phase_o), 1);
      chk(rail_t_o === '0 && rail_f_o === '0, "R3", "precharge rails",
          {rail_t_o, rail_f_o}, 0);
      chk(vld_o === 1'b0, "R9", "valid low in evaluate", 32'(vld_o), 0);
    end
    @(negedge clk);
    chk(res_o === e, op_req(op), "result", res_o, e);
    chk(vld_o === 1'b1, "R9", "valid pulse", 32'(vld_o), 1);
    chk(rail_t_o === ~rail_f_o && rail_t_o === res_o, "R4", "one rail per bit",
        {rail_t_o, rail_f_o}, {e, ~e});
    chk(err_o === '0, "R11", "no rail error", err_o, 0);
    // inputs changed during the following precharge cycle must be ignored
    a_i = ~a; b_i = b + 4'd5; op_i = op + 2'd1;
    @(negedge clk);
    if (verbose) begin
      chk(res_o === e, "R10", "result held", res_o, e);
      chk(vld_o === 1'b0, "R9", "valid one cycle", 32'(vld_o), 0);
      chk(rail_t_o === '0 && rail_f_o === '0, "R3", "rails zero after",
          {rail_t_o, rail_f_o}, 0);
      chk(phase_o === 1'b1, "R2", "phase toggles", 32'(phase_o), 1);
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(phase_o === 1'b0 && vld_o === 1'b0, "R1", "phase/valid in reset",
        {phase_o, vld_o}, 0);
    chk(res_o === '0 && rail_t_o === '0 && rail_f_o === '0 && err_o === '0,
        "R1", "data in reset", {res_o, rail_t_o, rail_f_o, err_o}, 0);
    rst = 1'b0;
    chk(phase_o === 1'b0, "R1", "first cycle precharge", 32'(phase_o), 0);
  endtask

  task automatic test_and();
    run_op(4'b1100, 4'b1010, 2'd0, 1'b1);
    run_op(4'b1111, 4'b1111, 2'd0, 1'b1);
  endtask

  task automatic test_or();
    run_op(4'b0000, 4'b0000, 2'd1, 1'b1);
    run_op(4'b1000, 4'b0011, 2'd1, 1'b1);
  endtask

  task automatic test_xor();
    run_op(4'b0110, 4'b0101, 2'd2, 1'b1);
    run_op(4'b1111, 4'b0000, 2'd2, 1'b1);
  endtask

  task automatic test_xnor();
    run_op(4'b0110, 4'b0101, 2'd3, 1'b1);
    run_op(4'b0000, 4'b0000, 2'd3, 1'b1);
  endtask

  task automatic test_sweep();
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_op(4'(a), 4'(b), 2'(op), 1'b0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_and();
    test_or();
    test_xor();
    test_xnor();
    test_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule